// File: doc/BRIEF.md
# Configurable Look-Up Logic Cell

This block is one programmable logic cell, meant to be tiled many times inside a larger fabric. Its core is a 16-bit store addressed by four data inputs. The store can act in three ways. It can be a fixed truth table, which means the cell computes any Boolean function of its four inputs. It can be a 16x1 RAM written on the clock edge. It can be a 16-bit shift register.

The contents are loaded serially through a configuration port that is open only while its enable is high. The most significant entry is sent first. The look-up result is available directly. It also feeds a flip-flop that has a clock enable and a synchronous set/reset, and the level that set/reset forces is itself configurable. An output select picks either the direct result or the registered copy for the cell's main output.

An active-low reset clears the store and the flip-flop.

Top module: `lutcell_top`

## Requirements
- R1: `lutOut` always equals the store entry whose index is `{dIn[3],dIn[2],dIn[1],dIn[0]}`, with `dIn[3]` as the most significant address bit and `dIn[0]` as the least.
- R2: On each rising clock edge with `cfgEn` high, every entry moves up one place, entry 0 takes `cfgBit` and the old entry 15 is dropped. Sixteen such edges, with the bit for entry 15 driven first, load the whole table.
- R3: With `storeMode` = 0 (fixed table) and `cfgEn` low, the store never changes, whatever `wrEn`, `wrData`, `shEn` and `shIn` do.
- R4: With `storeMode` = 1 (RAM) and `cfgEn` low, a rising edge with `wrEn` high writes `wrData` into the entry addressed by `dIn`, and only that entry. The new value can be read at `lutOut` in the same cycle after the edge.
- R5: With `storeMode` = 2 (shift), `cfgEn` low and `shEn` high, each rising edge moves the entries up by one and loads `shIn` into entry 0. With `shEn` low the store holds. `shOut` always shows entry 15, and `lutOut` keeps reading the addressed entry.
- R6: `cfgEn` takes priority over RAM writes and shift steps. While it is high, only the configuration shift happens.
- R7: When `sr` is low, a rising edge with `ce` high loads the flip-flop with the `lutOut` value from before that edge. With `ce` low the flip-flop holds.
- R8: A rising edge with `sr` high forces the flip-flop to `srLevel`, whatever the value of `ce`.
- R9: `cellOut` equals the flip-flop output when `outSel` is 1, and `lutOut` when `outSel` is 0.
- R10: While `rstN` is low, the store and the flip-flop are 0, so `lutOut`, `cellOut` and `shOut` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dIn | input | 4 | Look-up address; dIn[3] is the most significant bit |
| cfgEn | input | 1 | Configuration shift enable |
| cfgBit | input | 1 | Serial configuration data |
| storeMode | input | 2 | 0 fixed table, 1 RAM, 2 shift register, 3 acts as fixed table |
| wrEn | input | 1 | RAM write enable |
| wrData | input | 1 | RAM write data |
| shEn | input | 1 | Shift step enable |
| shIn | input | 1 | Bit shifted into entry 0 |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Synchronous set/reset of the flip-flop |
| srLevel | input | 1 | Value forced by sr |
| outSel | input | 1 | 1 selects the flip-flop for cellOut |
| lutOut | output | 1 | Combinational look-up result |
| cellOut | output | 1 | Selected output |
| shOut | output | 1 | Entry 15 of the store |

## Verification
The hardest cases to reach are the collisions where the store would be written from two sides in the same cycle. One is a configuration shift arriving while RAM writes or shift steps are requested. The other is a fixed-table cell that sees write and shift strobes it must ignore.

The stimulus holds `wrEn` or `shEn` high for whole sweeps while `cfgEn` is asserted, and repeats those sweeps in fixed-table mode. A behavioural model then shows any stray write, either on the next look-up or on `shOut`.

Flip-flop hold is checked by freezing `ce` while the address walks through entries that differ from the captured bit.

// File: rtl/lutcell_pkg.sv
`timescale 1ns/1ps
package lutcell_pkg;

  typedef enum logic [1:0] {
    MODE_ROM   = 2'd0,
    MODE_RAM   = 2'd1,
    MODE_SHIFT = 2'd2
  } cellMode_t;

  typedef struct packed {
    logic cfgShift;  // configuration shift this edge
    logic ramWr;     // single-entry write this edge
    logic shStep;    // user shift this edge
    logic ffForce;   // flip-flop forced to srLevel
    logic ffLoad;    // flip-flop captures look-up value
  } cellStrobe_t;

endpackage

// File: rtl/lutcell_ctrl.sv
`timescale 1ns/1ps
module lutcell_ctrl
  import lutcell_pkg::*;
(
  input  logic [1:0]  storeMode,
  input  logic        cfgEn,
  input  logic        wrEn,
  input  logic        shEn,
  input  logic        ce,
  input  logic        sr,
  output cellStrobe_t strobe
);

  logic isRam;
  logic isShift;

  assign isRam   = (storeMode == MODE_RAM);
  assign isShift = (storeMode == MODE_SHIFT);

  always_comb begin
    strobe          = '0;
    strobe.cfgShift = cfgEn;
    strobe.ramWr    = !cfgEn && isRam && wrEn;
    strobe.shStep   = !cfgEn && isShift && shEn;
    strobe.ffForce  = sr;
    strobe.ffLoad   = !sr && ce;
  end

endmodule

// File: rtl/lutcell_dp.sv
`timescale 1ns/1ps
module lutcell_dp
  import lutcell_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cellStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       cfgBit,
  input  logic                       wrData,
  input  logic                       shIn,
  input  logic                       srLevel,
  input  logic                       outSel,
  output logic                       lutOut,
  output logic                       cellOut,
  output logic                       shOut,
  output logic [(1<<ADDR_W)-1:0]     memBits,
  output logic                       ffQ
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem;
  logic [DEPTH-1:0] memNext;
  logic             shiftAny;
  logic             headBit;

  assign shiftAny = strobe.cfgShift || strobe.shStep;
  assign headBit  = strobe.cfgShift ? cfgBit : shIn;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic lowerBit;
    if (i == 0) begin : g_head
      assign lowerBit = headBit;
    end else begin : g_body
      assign lowerBit = mem[i-1];
    end
    assign memNext[i] = shiftAny ? lowerBit :
                        (strobe.ramWr && (addr == ADDR_W'(i))) ? wrData :
                        mem[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mem <= '0;
    else       mem <= memNext;
  end

  assign lutOut = mem[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ffQ <= 1'b0;
    else if (strobe.ffForce) ffQ <= srLevel;
    else if (strobe.ffLoad)  ffQ <= lutOut;
  end

  assign cellOut = outSel ? ffQ : lutOut;
  assign shOut   = mem[DEPTH-1];
  assign memBits = mem;

endmodule

// File: rtl/lutcell_top.sv
`timescale 1ns/1ps
module lutcell_top
  import lutcell_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dIn,
  input  logic              cfgEn,
  input  logic              cfgBit,
  input  logic [1:0]        storeMode,
  input  logic              wrEn,
  input  logic              wrData,
  input  logic              shEn,
  input  logic              shIn,
  input  logic              ce,
  input  logic              sr,
  input  logic              srLevel,
  input  logic              outSel,
  output logic              lutOut,
  output logic              cellOut,
  output logic              shOut
);

  localparam int DEPTH = 1 << ADDR_W;

  cellStrobe_t      strobe;
  logic [DEPTH-1:0] memBits;
  logic             ffQ;

  lutcell_ctrl u_ctrl (
    .storeMode (storeMode),
    .cfgEn     (cfgEn),
    .wrEn      (wrEn),
    .shEn      (shEn),
    .ce        (ce),
    .sr        (sr),
    .strobe    (strobe)
  );

  lutcell_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (dIn),
    .cfgBit  (cfgBit),
    .wrData  (wrData),
    .shIn    (shIn),
    .srLevel (srLevel),
    .outSel  (outSel),
    .lutOut  (lutOut),
    .cellOut (cellOut),
    .shOut   (shOut),
    .memBits (memBits),
    .ffQ     (ffQ)
  );

endmodule

// File: rtl/lutcell_chk.sv
`timescale 1ns/1ps
module lutcell_chk #(
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgEn,
  input logic                   cfgBit,
  input logic [1:0]             storeMode,
  input logic                   wrEn,
  input logic                   shEn,
  input logic                   shIn,
  input logic                   ce,
  input logic                   sr,
  input logic                   srLevel,
  input logic [(1<<ADDR_W)-1:0] memBits,
  input logic                   ffQ
);

  localparam int DEPTH = 1 << ADDR_W;

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> memBits == {$past(memBits[DEPTH-2:0]), $past(cfgBit)}); // R2

  AST_ROM_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && storeMode == 2'd0) |=> $stable(memBits)); // R3

  AST_RAM_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && storeMode == 2'd1 && wrEn) |=> $countones(memBits ^ $past(memBits)) <= 1); // R4

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && storeMode == 2'd2 && shEn) |=> memBits == {$past(memBits[DEPTH-2:0]), $past(shIn)}); // R5

  AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sr && !ce) |=> $stable(ffQ)); // R7

  AST_SR_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    sr |=> ffQ == $past(srLevel)); // R8

endmodule

bind lutcell_top lutcell_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgEn     (cfgEn),
  .cfgBit    (cfgBit),
  .storeMode (storeMode),
  .wrEn      (wrEn),
  .shEn      (shEn),
  .shIn      (shIn),
  .ce        (ce),
  .sr        (sr),
  .srLevel   (srLevel),
  .memBits   (memBits),
  .ffQ       (ffQ)
);

// File: tb/sim_lutcell_top.sv
`timescale 1ns/1ps
module sim_lutcell_top;

  localparam logic [15:0] TT  = 16'hB38E;
  localparam logic [15:0] PAT = 16'hC5A3;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] dIn;
  logic       cfgEn, cfgBit, wrEn, wrData, shEn, shIn, ce, sr, srLevel, outSel;
  logic [1:0] storeMode;
  logic       lutOut, cellOut, shOut;

  int    checks = 0;
  int    errors = 0;
  bit    chkOn  = 1'b0;
  string curReq = "R10";

  bit refMem[$];
  bit refFf;
  bit lv;

  always #2.5 clk = ~clk;

  lutcell_top u0 (
    .clk(clk), .rstN(rstN), .dIn(dIn), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .storeMode(storeMode), .wrEn(wrEn), .wrData(wrData), .shEn(shEn),
    .shIn(shIn), .ce(ce), .sr(sr), .srLevel(srLevel), .outSel(outSel),
    .lutOut(lutOut), .cellOut(cellOut), .shOut(shOut)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  // reference model, updated at every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) refMem[i] = 1'b0;
      refFf = 1'b0;
    end else begin
      lv = refMem[dIn];
      if (sr) refFf = srLevel;
      else if (ce) refFf = lv;
      if (cfgEn) begin
        refMem.push_front(cfgBit);
        void'(refMem.pop_back());
      end else if (storeMode == 2'd2 && shEn) begin
        refMem.push_front(shIn);
        void'(refMem.pop_back());
      end else if (storeMode == 2'd1 && wrEn) begin
        refMem[dIn] = wrData;
      end
    end
  end

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (chkOn) begin
      check(lutOut,  refMem[dIn],                   {curReq, " lutOut"});
      check(cellOut, outSel ? refFf : refMem[dIn],  {curReq, " cellOut"});
      check(shOut,   refMem[15],                    {curReq, " shOut"});
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) refMem.push_back(1'b0);
    refFf = 1'b0;
    rstN = 1'b0; dIn = '0; cfgEn = 0; cfgBit = 0; storeMode = 2'd0;
    wrEn = 0; wrData = 0; shEn = 0; shIn = 0; ce = 0; sr = 0; srLevel = 0; outSel = 0;

    // R10: reset state
    repeat (2) nxt();
    chkOn = 1'b1;
    curReq = "R10";
    outSel = 1;
    nxt();
    @(negedge clk);
    check(lutOut | cellOut | shOut, 1'b0, "R10 outputs in reset");
    nxt();
    rstN = 1'b1;
    outSel = 0;

    // R2: serial load, entry 15 first; R6 with shift strobes present
    curReq = "R2";
    cfgEn = 1; storeMode = 2'd2; shEn = 1; shIn = 0;
    for (int i = 15; i >= 0; i--) begin
      cfgBit = TT[i];
      nxt();
    end
    cfgEn = 0; shEn = 0; storeMode = 2'd0;

    // R1: every input pattern against the loaded table
    curReq = "R1";
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i);
      @(negedge clk);
      check(lutOut, TT[i], "R1 table entry");
      nxt();
    end

    // R3: fixed table ignores write and shift strobes
    curReq = "R3";
    wrEn = 1; shEn = 1; shIn = 1;
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i); wrData = ~TT[i];
      nxt();
    end
    wrEn = 0; shEn = 0;
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(15 - i);
      @(negedge clk);
      check(lutOut, TT[15 - i], "R3 table unchanged");
      nxt();
    end

    // R4: RAM write and readback
    curReq = "R4";
    storeMode = 2'd1;
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i); wrData = i[0] ^ i[2]; wrEn = 1;
      nxt();
    end
    wrEn = 0;
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i);
      @(negedge clk);
      check(lutOut, i[0] ^ i[2], "R4 ram readback");
      nxt();
    end

    // R6: configuration wins over RAM writes
    curReq = "R6";
    cfgEn = 1; cfgBit = 1; wrEn = 1; wrData = 0;
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i);
      nxt();
    end
    cfgEn = 0; wrEn = 0;
    dIn = 4'd6;
    @(negedge clk);
    check(lutOut, 1'b1, "R6 config over ram");
    nxt();

    // R5: sixteen shift steps, first bit pushed ends in entry 15
    curReq = "R5";
    storeMode = 2'd2; shEn = 1;
    for (int k = 15; k >= 0; k--) begin
      shIn = PAT[k]; dIn = 4'(k);
      nxt();
    end
    shEn = 0; shIn = 0;
    @(negedge clk);
    check(shOut, PAT[15], "R5 shOut after 16 steps");
    nxt();
    nxt();
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i);
      @(negedge clk);
      check(lutOut, PAT[i], "R5 shifted contents");
      nxt();
    end

    // R7/R9: capture then hold while the address walks
    curReq = "R7";
    storeMode = 2'd0; outSel = 1; dIn = 4'd0; ce = 1;
    nxt();
    ce = 0;
    for (int i = 0; i < 16; i++) begin
      dIn = 4'(i);
      @(negedge clk);
      check(cellOut, PAT[0], "R7 flip-flop holds");
      nxt();
    end
    ce = 1;
    for (int i = 0; i < 8; i++) begin
      dIn = 4'(i * 2 + 1);
      nxt();
    end

    // R8: set/reset beats the clock enable
    curReq = "R8";
    ce = 0; sr = 1; srLevel = 1;
    nxt();
    @(negedge clk);
    check(cellOut, 1'b1, "R8 forced high");
    ce = 1; srLevel = 0; dIn = 4'd0;
    nxt();
    @(negedge clk);
    check(cellOut, 1'b0, "R8 forced low over ce");
    sr = 0; ce = 0;
    nxt();

    // R9: output select toggling
    curReq = "R9";
    for (int i = 0; i < 16; i++) begin
      outSel = i[0]; dIn = 4'(i); ce = i[1];
      nxt();
    end

    chkOn = 1'b0;
    finishRun();
  end

endmodule